// File: doc/BRIEF.md
# Receiver Marked-Address Match Filter

This block sits on the receive path of a serial port, between the deserializer and the receive data buffer, and decides which frames reach the buffer. Each frame arrives with a separate address-mark bit. The deserializer places that bit in the slot that a parity bit would take in the 8-bit and 9-bit formats, so the filter only ever sees it as a flag. A marked frame is an address. It is compared against two programmable match words, each with its own enable. A hit forwards the address and opens a gate for the unmarked data frames that follow. A miss drops the address and shuts the gate, so the data frames behind it are dropped as well.

Both sides of the data path use valid/ready. The filter holds one frame in its output register. It accepts a new frame when that register is empty or is being emptied in the same cycle, so `in_ready = !out_valid || out_ready`. A frame on the input is consumed only on `in_valid && in_ready`, whether it is forwarded or dropped. While the buffer stalls (`out_valid && !out_ready`), the output frame holds steady and nothing new is consumed. A sticky data-ready flag reports that the buffer was written. The reader clears it with an acknowledge pulse.

Filtering is switched off when both match enables are low, and also when smart-card mode is on. In either case every frame is forwarded.

Top module: `mafilt_addr_filter`

## Requirements
- R1: After reset, `out_valid` = 0, `data_ready` = 0, `in_ready` = 1, and the gate is shut.
- R2: With both match enables low and smart-card mode off, every consumed frame is forwarded, whatever its mark. `out_valid` rises on the next cycle with `out_data` equal to the consumed word.
- R3: With `smartcard_mode` = 1, every consumed frame is forwarded, whatever the enables, the match words and the mark.
- R4: With exactly one enable high, a marked frame is forwarded only if its word equals that enable's match word. The other match word is ignored.
- R5: With both enables high, a marked frame is forwarded if its word equals either match word.
- R6: A forwarded marked frame opens the gate. Every following unmarked frame (`in_mark` = 0) is forwarded while filtering is active.
- R7: A marked frame that matches no enabled word is dropped (`out_valid` = 0 on the next cycle). It shuts the gate, so the unmarked frames after it are dropped too.
- R8: Unmarked frames consumed after reset, before any matching address, are dropped while filtering is active.
- R9: Frames consumed while filtering is off leave the gate state unchanged. An open gate stays open once filtering is switched back on.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, `out_valid` stays 1 and `out_data` stays stable.
- R11: `data_ready` becomes 1 on the cycle after a write (`out_valid && out_ready`). An `rd_ack` clears it on the next edge. When a write and `rd_ack` fall in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Received frame present |
| in_ready | output | 1 | Filter can consume a frame this cycle |
| in_data | input | DATA_W | Received data word |
| in_mark | input | 1 | Address-mark bit of the frame |
| out_valid | output | 1 | Forwarded frame waiting for the buffer |
| out_ready | input | 1 | Buffer accepts the frame |
| out_data | output | DATA_W | Forwarded data word |
| match_a | input | DATA_W | First match word |
| match_b | input | DATA_W | Second match word |
| match_en_a | input | 1 | Enable for the first match word |
| match_en_b | input | 1 | Enable for the second match word |
| smartcard_mode | input | 1 | Smart-card mode; switches filtering off |
| rd_ack | input | 1 | Read acknowledge; clears the data-ready flag |
| data_ready | output | 1 | Sticky flag: buffer written since last read |

## Verification
The bench aims at the gate's memory across frames. It sends unmarked frames straight after reset, which a filter that starts with the gate open would wrongly forward. It sends a marked word equal to the disabled match register, which a filter that compares against both registers would pass. It toggles bypass in the middle of a stream, which a filter that resets or rewrites the gate while bypassed would get wrong on the next data frame. Random back-pressure tests that stalled frames are held and not lost or duplicated, and a write that coincides with a read acknowledge tests that the flag set wins over the clear.

// File: rtl/mafilt_pkg.sv
package mafilt_pkg;

  typedef enum logic {
    GATE_SHUT = 1'b0,
    GATE_OPEN = 1'b1
  } gate_e;

  typedef struct packed {
    logic  fwd;   // forward the frame to the buffer
    logic  load;  // frame updates the gate state
    gate_e next;  // gate state to load
  } verdict_t;

endpackage

// File: rtl/mafilt_addr_cmp.sv
module mafilt_addr_cmp #(
  parameter int DATA_W    = 9,
  parameter int NUM_MATCH = 2
) (
  input  logic [DATA_W-1:0]           word,
  input  logic [NUM_MATCH*DATA_W-1:0] match_flat,
  input  logic [NUM_MATCH-1:0]        enable,
  output logic                        any_en,
  output logic                        hit
);

  logic [NUM_MATCH-1:0] eq;

  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
    assign eq[g] = enable[g] && (word == match_flat[g*DATA_W +: DATA_W]);
  end

  assign hit    = |eq;
  assign any_en = |enable;

endmodule

// File: rtl/mafilt_gate.sv
module mafilt_gate
  import mafilt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic mark,
  input  logic any_en,
  input  logic hit,
  input  logic smartcard,
  output logic fwd
);

  gate_e    state;
  verdict_t v;
  logic     bypass;

  assign bypass = smartcard || !any_en;

  always_comb begin
    v = '{fwd: 1'b0, load: 1'b0, next: GATE_SHUT};
    if (bypass) begin
      v.fwd = 1'b1;
    end else if (mark) begin
      v.fwd  = hit;
      v.load = 1'b1;
      v.next = hit ? GATE_OPEN : GATE_SHUT;
    end else begin
      v.fwd = (state == GATE_OPEN);
    end
  end

  assign fwd = v.fwd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= GATE_SHUT;
    end else if (fire && v.load) begin
      state <= v.next;
    end
  end

endmodule

// File: rtl/mafilt_out_stage.sv
module mafilt_out_stage #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              fwd,
  output logic              in_ready,
  output logic              fire,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              wr_fire
);

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign wr_fire  = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= fwd;
      if (fwd) out_data <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mafilt_ready_flag.sv
module mafilt_ready_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

endmodule

// File: rtl/mafilt_addr_filter.sv
module mafilt_addr_filter #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mark,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic [DATA_W-1:0] match_a,
  input  logic [DATA_W-1:0] match_b,
  input  logic              match_en_a,
  input  logic              match_en_b,
  input  logic              smartcard_mode,
  input  logic              rd_ack,
  output logic              data_ready
);

  localparam int NUM_MATCH = 2;

  logic [NUM_MATCH*DATA_W-1:0] match_flat;
  logic [NUM_MATCH-1:0]        enable;
  logic any_en, hit, fwd, fire, wr_fire;

  assign match_flat = {match_b, match_a};
  assign enable     = {match_en_b, match_en_a};

  mafilt_addr_cmp #(.DATA_W(DATA_W), .NUM_MATCH(NUM_MATCH)) u_cmp (
    .word(in_data), .match_flat(match_flat), .enable(enable),
    .any_en(any_en), .hit(hit)
  );

  mafilt_gate u_gate (
    .clk(clk), .rst_n(rst_n), .fire(fire), .mark(in_mark),
    .any_en(any_en), .hit(hit), .smartcard(smartcard_mode), .fwd(fwd)
  );

  mafilt_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .fwd(fwd), .in_ready(in_ready), .fire(fire), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .wr_fire(wr_fire)
  );

  mafilt_ready_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(wr_fire), .clr(rd_ack), .flag(data_ready)
  );

endmodule

// File: rtl/mafilt_checker.sv
module mafilt_checker #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_mark,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [DATA_W-1:0] match_a,
  input logic [DATA_W-1:0] match_b,
  input logic              match_en_a,
  input logic              match_en_b,
  input logic              smartcard_mode,
  input logic              rd_ack,
  input logic              data_ready
);

  logic take, off, any_hit;
  assign take    = in_valid && in_ready;
  assign off     = smartcard_mode || !(match_en_a || match_en_b);
  assign any_hit = (match_en_a && in_data == match_a) || (match_en_b && in_data == match_b);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
  AST_BYPASS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    take && off |=> out_valid && out_data == $past(in_data)); // R2
  AST_SMARTCARD_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    take && smartcard_mode |=> out_valid); // R3
  AST_MARK_HIT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    take && !off && in_mark && any_hit |=> out_valid && out_data == $past(in_data)); // R5
  AST_MARK_MISS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    take && !off && in_mark && !any_hit |=> !out_valid); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> data_ready); // R11
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !(out_valid && out_ready) |=> !data_ready); // R11

endmodule

bind mafilt_addr_filter mafilt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_mark(in_mark), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .match_a(match_a),
  .match_b(match_b), .match_en_a(match_en_a), .match_en_b(match_en_b),
  .smartcard_mode(smartcard_mode), .rd_ack(rd_ack), .data_ready(data_ready)
);

// File: tb/test_mafilt_addr_filter.sv
module test_mafilt_addr_filter;

  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_mark = 1'b0, out_ready = 1'b0, rd_ack = 1'b0;
  logic [DW-1:0] in_data = '0, match_a = '0, match_b = '0;
  logic en_a = 1'b0, en_b = 1'b0, sc = 1'b0;
  logic in_ready, out_valid, data_ready;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk;

  mafilt_addr_filter #(.DATA_W(DW)) i_mafilt_addr_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mark(in_mark), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .match_a(match_a),
    .match_b(match_b), .match_en_a(en_a), .match_en_b(en_b),
    .smartcard_mode(sc), .rd_ack(rd_ack), .data_ready(data_ready)
  );

  int vectors = 0, misses = 0, cyc = 0;

  // reference model state
  logic          m_v = 1'b0, m_flag = 1'b0, m_open = 1'b0;
  logic [DW-1:0] m_d = '0;
  string         m_tag = "R1";

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      misses++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic model_hit(input logic [DW-1:0] d);
    return (en_a && d == match_a) || (en_b && d == match_b);
  endfunction

  // one clock: compare outputs with the model, drive inputs, advance the model
  task automatic cycle(input logic v, input logic [DW-1:0] d, input logic mk,
                       input logic ordy, input logic rd);
    logic fire, fwd, off;
    check(out_valid == m_v, m_tag, int'(out_valid), int'(m_v));
    if (m_v) check(out_data == m_d, m_tag, int'(out_data), int'(m_d));
    check(data_ready == m_flag, "R11 data_ready", int'(data_ready), int'(m_flag));
    in_valid = v; in_data = d; in_mark = mk; out_ready = ordy; rd_ack = rd;
    #1;
    check(in_ready == (!m_v || ordy), "R10 in_ready", int'(in_ready), int'(!m_v || ordy));
    fire   = v && (!m_v || ordy);
    m_flag = (m_v && ordy) ? 1'b1 : (rd ? 1'b0 : m_flag);
    off    = sc || !(en_a || en_b);
    if (fire) begin
      if (off) begin
        fwd = 1'b1; m_tag = sc ? "R3 smartcard pass" : "R2 bypass pass";
      end else if (mk) begin
        fwd = model_hit(d); m_open = fwd;
        if (!fwd) m_tag = "R7 marked miss dropped";
        else m_tag = (en_a && en_b) ? "R5 either match" : "R4 single match";
      end else begin
        fwd = m_open;
        m_tag = fwd ? "R6 gated data pass" : "R8/R7 gated data dropped";
      end
      m_v = fwd;
      if (fwd) m_d = d;
    end else if (ordy) begin
      m_v = 1'b0;
      m_tag = "R10 drained";
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_01));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(data_ready == 1'b0, "R1 data_ready", int'(data_ready), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    // directed corner cases
    en_a = 1; en_b = 0; match_a = 9'h055; match_b = 9'h1AA;
    cycle(1, 9'h010, 0, 1, 0);            // R8 unmarked before any address
    check(out_valid == 1'b0, "R8 early data", int'(out_valid), 0);
    cycle(1, 9'h1AA, 1, 1, 0);            // R4 disabled register ignored
    check(out_valid == 1'b0, "R4 disabled reg", int'(out_valid), 0);
    cycle(1, 9'h055, 1, 1, 0);            // R4 hit
    cycle(1, 9'h022, 0, 1, 0);            // R6
    en_a = 0;
    cycle(1, 9'h077, 1, 1, 0);            // R2 bypass, gate untouched
    en_a = 1;
    cycle(1, 9'h033, 0, 1, 0);            // R9 gate still open
    check(out_valid == 1'b1 && out_data == 9'h033, "R9 gate kept", int'(out_data), 9'h033);
    sc = 1;
    cycle(1, 9'h099, 1, 1, 0);            // R3
    sc = 0;
    cycle(1, 9'h098, 1, 1, 0);            // R7 miss
    cycle(1, 9'h044, 0, 1, 0);            // R7 data after miss
    check(out_valid == 1'b0, "R7 data after miss", int'(out_valid), 0);
    en_b = 1;
    cycle(1, 9'h1AA, 1, 1, 0);            // R5 second register
    cycle(0, 9'h000, 0, 1, 1);            // R11 write and read ack together
    check(data_ready == 1'b1, "R11 set beats clear", int'(data_ready), 1);
    cycle(0, 9'h000, 0, 1, 1);
    check(data_ready == 1'b0, "R11 cleared", int'(data_ready), 0);
    cycle(1, 9'h055, 1, 0, 0);            // R10 stall
    cycle(1, 9'h011, 0, 0, 0);
    check(out_valid == 1'b1 && out_data == 9'h055, "R10 held", int'(out_data), 9'h055);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [DW-1:0] d;
      int pick;
      if (i % 64 == 0) begin
        en_a = 1'($urandom % 2); en_b = 1'($urandom % 2);
        sc = ($urandom % 6) == 0;
        match_a = DW'($urandom); match_b = DW'($urandom);
      end
      pick = int'($urandom % 4);
      d = (pick == 0) ? match_a : (pick == 1) ? match_b : DW'($urandom);
      cycle(($urandom % 4) != 0, d, ($urandom % 3) == 0,
            ($urandom % 4) != 0, ($urandom % 5) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule